// File: doc/BRIEF.md
# 16-to-8-bit bus width converter

This block connects a 16-bit processor bus to a mix of fast on-board 16-bit memory and slower external memory that is only eight bits wide. Every processor access is one 16-bit word. The address is decoded in the cycle the access starts.

Words that fall in the on-board ROM window or the scratchpad RAM window are routed to the 16-bit path. That path adds no wait state, so those accesses finish in the processor's two-cycle minimum. Every other address goes to the external byte bus. There the converter runs two back-to-back byte cycles, and each byte cycle is stretched by one wait state.

During an external access the processor's ready line is held low until the last cycle of the second byte. For reads, the first byte is kept in a register and returned together with the second byte as one word. For writes, the word is split into its two bytes and written out in the same order. An external word therefore takes six cycles, against two for the fast path.

Top module: `bw16to8_bridge`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, `cpu_ready` is 1, `ext_rd`, `ext_wr`, `rom_sel` and `ram_sel` are 0, and `cpu_rdata` is 0. Reset asserts at once, even in the middle of an external access.
- R2: A request to an address from 0x0000 to 0x1FFF drives `rom_sel`. It keeps `cpu_ready` high, returns `fast_rdata` on `cpu_rdata`, completes in two cycles and raises no external strobe.
- R3: A request to an address from 0x8300 to 0x83FF drives `ram_sel` and behaves like R2. The neighbouring addresses 0x2000, 0x82FF and 0x8400 are external.
- R4: An external request lasts six cycles. `cpu_ready` is 0 from its first cycle through its fifth cycle and is 1 in the sixth.
- R5: Cycles 1 to 3 of an external access use the odd byte address (`ext_addr` = word address with bit 0 set). Cycles 4 to 6 use the even byte address (bit 0 clear).
- R6: An external write drives `ext_wr` in all six cycles. `ext_wdata` carries `cpu_wdata[7:0]` in cycles 1 to 3 and `cpu_wdata[15:8]` in cycles 4 to 6. `ext_rd` stays 0.
- R7: An external read drives `ext_rd` in all six cycles. `cpu_rdata` is 0 in cycles 1 to 5. In cycle 6 it is {byte read in cycles 4-6, byte read in cycles 1-3}, with the second byte in the upper half.
- R8: If `cpu_req` stays high after the final cycle with a new external address, a fresh six-cycle sequence begins in the very next cycle.
- R9: With `cpu_req` low, no select or strobe is active, `cpu_ready` is 1 and `cpu_rdata` is 0. At most one of `rom_sel`, `ram_sel` and an external strobe is ever active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held for the whole access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor byte address of the word |
| cpu_wdata | input | 16 | Write word |
| cpu_rdata | output | 16 | Read word returned to the processor |
| cpu_ready | output | 1 | Low while the processor must wait |
| rom_sel | output | 1 | On-board ROM window selected |
| ram_sel | output | 1 | Scratchpad RAM window selected |
| fast_rdata | input | 16 | Read word from the fast 16-bit path |
| ext_addr | output | 16 | External byte address |
| ext_wdata | output | 8 | External write byte |
| ext_rdata | input | 8 | External read byte |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |

## Verification
Two events can share a single cycle: the final cycle of one external word, when the gathered word is presented and ready rises, and the decode of the next request, which the processor may issue without dropping `cpu_req`. The bench provokes this by running two external reads back to back with no idle cycle between them. It judges the second read on its own terms: it must last six full cycles, use the odd address first, and return its own bytes. Any data left over from the first word fails these checks. A reset dropped in the middle of an external read is also checked, to make sure ready and the strobes recover at once.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

  typedef struct packed {
    logic rom;
    logic ram;
    logic ext;
  } region_t;

endpackage

// File: rtl/bwb_decode.sv
module bwb_decode
  import bwb_pkg::*;
#(
  parameter int AW     = 16,
  parameter int ROM_LO = 'h0000,
  parameter int ROM_HI = 'h1FFF,
  parameter int RAM_LO = 'h8300,
  parameter int RAM_HI = 'h83FF
) (
  input  logic          req,
  input  logic [AW-1:0] addr,
  output region_t       hit
);

  logic in_rom, in_ram;

  always_comb begin
    in_rom  = (addr >= AW'(ROM_LO)) && (addr <= AW'(ROM_HI));
    in_ram  = (addr >= AW'(RAM_LO)) && (addr <= AW'(RAM_HI));
    hit.rom = req && in_rom;
    hit.ram = req && in_ram && !in_rom;
    hit.ext = req && !in_rom && !in_ram;
  end

endmodule

// File: rtl/bwb_seq.sv
module bwb_seq #(
  parameter int BASE_CYC = 2,
  parameter int WAIT_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic ready,
  output logic second,
  output logic capture,
  output logic last
);

  localparam int BYTE_CYC = BASE_CYC + WAIT_CYC;
  localparam int TOTAL    = 2 * BYTE_CYC;
  localparam int CW       = $clog2(TOTAL);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d, idx;
  logic          en;

  always_comb begin
    idx     = busy_q ? cnt_q : '0;
    last    = go && (idx == CW'(TOTAL - 1));
    second  = idx >= CW'(BYTE_CYC);
    capture = go && (idx == CW'(BYTE_CYC - 1));
    ready   = !go || last;
    en      = go || busy_q;
    busy_d  = 1'b0;
    cnt_d   = '0;
    if (go && !last) begin
      busy_d = 1'b1;
      cnt_d  = idx + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // R4: the processor is held in the first cycle of every external word
  a_r4_first_cycle_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy_q) |-> !ready);

  // R8: after the final cycle the count restarts from the beginning
  a_r8_restart_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q);

endmodule

// File: rtl/bwb_gather.sv
module bwb_gather #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            last,
  input  logic            fast_sel,
  input  logic [DW/2-1:0] ext_rdata,
  input  logic [DW-1:0]   fast_rdata,
  output logic [DW-1:0]   cpu_rdata
);

  localparam int BW = DW / 2;

  logic [BW-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (capture) begin
      lo_q <= ext_rdata;
    end
  end

  always_comb begin
    if (fast_sel)  cpu_rdata = fast_rdata;
    else if (last) cpu_rdata = {ext_rdata, lo_q};
    else           cpu_rdata = '0;
  end

  // R7: the first byte is kept exactly as it was read
  a_r7_low_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> lo_q == $past(ext_rdata));

endmodule

// File: rtl/bw16to8_bridge.sv
module bw16to8_bridge
  import bwb_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int BASE_CYC = 2,
  parameter int WAIT_CYC = 1,
  parameter int ROM_LO   = 'h0000,
  parameter int ROM_HI   = 'h1FFF,
  parameter int RAM_LO   = 'h8300,
  parameter int RAM_HI   = 'h83FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  output logic            cpu_ready,
  output logic            rom_sel,
  output logic            ram_sel,
  input  logic [DW-1:0]   fast_rdata,
  output logic [AW-1:0]   ext_addr,
  output logic [DW/2-1:0] ext_wdata,
  input  logic [DW/2-1:0] ext_rdata,
  output logic            ext_rd,
  output logic            ext_wr
);

  localparam int BW = DW / 2;

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       req_ok;
  region_t    hit;
  logic       second, capture, last;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];
  assign req_ok    = cpu_req && rst_int_n;

  bwb_decode #(
    .AW(AW), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)
  ) u_decode (
    .req  (req_ok),
    .addr (cpu_addr),
    .hit  (hit)
  );

  bwb_seq #(.BASE_CYC(BASE_CYC), .WAIT_CYC(WAIT_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .go      (hit.ext),
    .ready   (cpu_ready),
    .second  (second),
    .capture (capture),
    .last    (last)
  );

  bwb_gather #(.DW(DW)) u_gather (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .capture    (capture),
    .last       (last),
    .fast_sel   (hit.rom || hit.ram),
    .ext_rdata  (ext_rdata),
    .fast_rdata (fast_rdata),
    .cpu_rdata  (cpu_rdata)
  );

  always_comb begin
    rom_sel   = hit.rom;
    ram_sel   = hit.ram;
    ext_rd    = hit.ext && !cpu_we;
    ext_wr    = hit.ext && cpu_we;
    ext_addr  = {cpu_addr[AW-1:1], !second};
    ext_wdata = second ? cpu_wdata[DW-1:BW] : cpu_wdata[BW-1:0];
  end

  // R9: at most one destination is active
  a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({rom_sel, ram_sel, ext_rd || ext_wr}));

  // R2, R3: the fast path never stalls the processor
  a_r2_fast_no_wait: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rom_sel || ram_sel) |-> cpu_ready);

  // R5: the first byte half targets the odd address
  a_r5_odd_first: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((ext_rd || ext_wr) && !second) |-> ext_addr[0]);

  // R6: the second byte half of a write carries the upper byte
  a_r6_upper_second: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ext_wr && second) |-> (ext_wdata == cpu_wdata[DW-1:BW]));

endmodule

// File: tb/bw16to8_bridge_tb.sv
module bw16to8_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0, fast_rdata = '0;
  logic [15:0] cpu_rdata, ext_addr;
  logic [7:0]  ext_wdata, ext_rdata;
  logic        cpu_ready, rom_sel, ram_sel, ext_rd, ext_wr;
  logic [7:0]  m_lo = '0, m_hi = '0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;   // 250 MHz

  assign ext_rdata = ext_addr[0] ? m_lo : m_hi;

  bw16to8_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .rom_sel(rom_sel), .ram_sel(ram_sel),
    .fast_rdata(fast_rdata), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .ext_rd(ext_rd), .ext_wr(ext_wr)
  );

  // we | addr | wdata | fast word | odd byte | even byte
  localparam int NV = 11;
  localparam logic [64:0] VECS [NV] = '{
    {1'b0, 16'h0000, 16'h0000, 16'h1234, 8'h00, 8'h00},
    {1'b0, 16'h1FFF, 16'h0000, 16'hBEEF, 8'h11, 8'h22},
    {1'b0, 16'h2000, 16'h0000, 16'h5555, 8'h3C, 8'hA7},
    {1'b0, 16'h8300, 16'h0000, 16'hC0DE, 8'h00, 8'h00},
    {1'b0, 16'h83FF, 16'h0000, 16'h0F0F, 8'h99, 8'h88},
    {1'b0, 16'h82FF, 16'h0000, 16'h0000, 8'h01, 8'hFE},
    {1'b0, 16'h8400, 16'h0000, 16'h0000, 8'h80, 8'h7F},
    {1'b1, 16'hA000, 16'h9A5C, 16'h0000, 8'h00, 8'h00},
    {1'b1, 16'h8310, 16'h4321, 16'h0000, 8'h00, 8'h00},
    {1'b0, 16'hFFFE, 16'h0000, 16'h0000, 8'hC3, 8'h5A},
    {1'b1, 16'h1000, 16'hFFFF, 16'h0000, 8'h00, 8'h00}
  };

  function automatic bit in_rom(input logic [15:0] a);
    return a <= 16'h1FFF;
  endfunction
  function automatic bit in_ram(input logic [15:0] a);
    return a >= 16'h8300 && a <= 16'h83FF;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_check(input string tag);
    cpu_req = 1'b0;
    @(negedge clk);
    check(cpu_ready === 1'b1, {tag, " ready"}, 32'(cpu_ready), 1);
    check({rom_sel, ram_sel, ext_rd, ext_wr} === 4'b0, {tag, " selects"},
          32'({rom_sel, ram_sel, ext_rd, ext_wr}), 0);
    check(cpu_rdata === 16'h0, {tag, " rdata"}, 32'(cpu_rdata), 0);
    @(posedge clk); #1;
  endtask

  // starts just after a rising edge, leaves cpu_req high after the final cycle
  task automatic access(input logic we, input logic [15:0] a, wd, fr, input logic [7:0] lo, hi);
    bit fast, done;
    int len;
    logic [15:0] exp_rd;
    fast = in_rom(a) || in_ram(a);
    exp_rd = fast ? fr : {hi, lo};
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    fast_rdata = fr; m_lo = lo; m_hi = hi;
    done = 1'b0; len = 0;
    for (int cyc = 1; cyc <= 20 && !done; cyc++) begin
      @(negedge clk);
      if (fast) begin
        check(rom_sel === in_rom(a) && ram_sel === in_ram(a), "R2/R3 decode",
              32'({rom_sel, ram_sel}), 32'({in_rom(a), in_ram(a)}));
        check({ext_rd, ext_wr} === 2'b00, "R2/R3 no external strobe", 32'({ext_rd, ext_wr}), 0);
        check(cpu_ready === 1'b1, "R2/R3 ready", 32'(cpu_ready), 1);
      end else begin
        logic [15:0] ea;
        ea = (cyc <= 3) ? (a | 16'h0001) : (a & 16'hFFFE);
        check(ext_addr === ea, "R5 byte address", 32'(ext_addr), 32'(ea));
        check(ext_rd === !we && ext_wr === we, we ? "R6 write strobe" : "R7 read strobe",
              32'({ext_rd, ext_wr}), 32'({!we, we}));
        if (we)
          check(ext_wdata === ((cyc <= 3) ? wd[7:0] : wd[15:8]), "R6 write byte",
                32'(ext_wdata), 32'((cyc <= 3) ? wd[7:0] : wd[15:8]));
        if (cyc < 6) begin
          check(cpu_ready === 1'b0, "R4 ready low", 32'(cpu_ready), 0);
          if (!we) check(cpu_rdata === 16'h0, "R7 early rdata", 32'(cpu_rdata), 0);
        end
      end
      if (cpu_ready === 1'b1 && cyc >= 2) begin
        done = 1'b1; len = cyc;
        if (!we) check(cpu_rdata === exp_rd, fast ? "R2/R3 read word" : "R7 gathered word",
                       32'(cpu_rdata), 32'(exp_rd));
      end
      @(posedge clk); #1;
    end
    check(len == (fast ? 2 : 6), fast ? "R2/R3 length" : "R4 length", 32'(len), fast ? 2 : 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: held in reset with a request pending
    cpu_req = 1'b1; cpu_addr = 16'h4000;
    repeat (3) @(negedge clk);
    check(cpu_ready === 1'b1 && ext_rd === 1'b0, "R1 reset outputs",
          32'({cpu_ready, ext_rd}), 32'h2);
    check(cpu_rdata === 16'h0, "R1 reset rdata", 32'(cpu_rdata), 0);
    cpu_req = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    idle_check("R1 after release");

    for (int i = 0; i < NV; i++) begin
      access(VECS[i][64], VECS[i][63:48], VECS[i][47:32], VECS[i][31:16],
             VECS[i][15:8], VECS[i][7:0]);
      idle_check("R9 idle");
    end

    // R8: back-to-back external reads, request never dropped
    access(1'b0, 16'h6000, 16'h0, 16'h0, 8'h12, 8'h34);
    access(1'b0, 16'h6002, 16'h0, 16'h0, 8'hAB, 8'hCD);
    access(1'b1, 16'h6004, 16'h7E81, 16'h0, 8'h00, 8'h00);
    idle_check("R8 idle");

    // R1: reset dropped in the middle of an external read
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h5000;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check(cpu_ready === 1'b1 && ext_rd === 1'b0, "R1 mid-access reset",
          32'({cpu_ready, ext_rd}), 32'h2);
    cpu_req = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    idle_check("R1 recovery");
    access(1'b0, 16'h5000, 16'h0, 16'h0, 8'h66, 8'h77);
    idle_check("R9 final");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule